// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from reset to a usable state. It leaves clock enable low and holds the command bus at no-operation while it counts out a start-up delay derived from a clock-period parameter. Clock enable rises partway through that delay. When the delay has run out, the block issues an all-bank precharge, a configurable number of auto refresh commands and a mode register load, and it waits a fixed number of cycles after each of them. Once the wait after the final command has run out, it raises a ready flag, and a downstream controller can then take over the bus.

A compile-time switch selects the order of the refresh commands and the mode load. Each spacing is given in nanoseconds and is converted to clock cycles by rounding up. The mode word is also a parameter.

Top module: `sdram_power_up_seq`

## Requirements
- R1: While `rst` is high, `cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} read 0111 (no-operation), `ba` and `addr` are 0 and `init_done` is 0.
- R2: Counting clock edges after `rst` falls, the bus shows only no-operation (0111) for the first STARTUP cycles, where STARTUP = ceil(STARTUP_NS / clock period), which is 25000 with the default parameters. The first real command appears after edge STARTUP+1.
- R3: `cke` rises after edge CKE_RISE = ceil(CKE_RISE_NS / period), which is 12500 by default. It stays high from then on, and no-operation continues until the start-up window ends.
- R4: The first command is precharge-all: pins 0010, `addr` bit 10 high with every other address bit 0, `ba` = 0.
- R5: With REFRESH_AFTER_MODE = 0 the command order is precharge, N_REFRESH auto refresh commands, then mode load.
- R6: With REFRESH_AFTER_MODE = 1 the command order is precharge, mode load, then N_REFRESH auto refresh commands.
- R7: Auto refresh drives pins 0001 with `addr` = 0. Mode load drives pins 0000 with MODE_WORD on addr[11:0]. `ba` = 0 for both.
- R8: The number of cycles from one command to the next is exactly the ceiling, in cycles, of the spacing for the earlier command: 5 after precharge, 18 after a refresh and 4 after a mode load by default. Every cycle in between shows no-operation.
- R9: `init_done` rises exactly the mode-load or refresh spacing cycles after the last command, depending on which command came last, and stays high with the bus at no-operation.
- R10: Asserting `rst` at any point, including partway through the start-up window, returns the block to its reset state, and the whole sequence then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, always 0 here |
| addr | output | ADDR_W | Address bus; carries the all-bank bit and the mode word |
| init_done | output | 1 | High once the sequence is complete |

## Verification
Two events coincide on one edge. When the spacing counter after the last command expires, the ready flag rises and no new command is issued. The same edge that ends the last spacing therefore also changes `init_done`. Both orderings are run side by side, and the last command is a mode load in one and a refresh in the other, so this hand-off happens after a 4-cycle gap in one case and an 18-cycle gap in the other. A behavioural model in the bench predicts the exact edge of every command and of the ready flag. It compares all outputs on every cycle, so a flag that comes one cycle early or late, or a stray command on the edge where the flag rises, is reported. A reset applied partway through the window, after clock enable has risen, checks that the restart path clears clock enable as well.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } init_cmd_e;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_GAP  = 2'd1,
        PH_DONE = 2'd2
    } init_phase_e;

    // Rounds a time in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdram_init_step_table.sv
module sdram_init_step_table
    import sdram_init_pkg::*;
#(
    parameter int N_REFRESH          = 2,
    parameter bit REFRESH_AFTER_MODE = 1'b0,
    parameter int TRP_CYC            = 5,
    parameter int TRFC_CYC           = 18,
    parameter int TMRD_CYC           = 4,
    parameter int STEP_W             = 3,
    parameter int GAP_W              = 5
) (
    input  logic [STEP_W-1:0] step,
    output init_cmd_e         cmd,
    output logic [GAP_W-1:0]  gap
);

    generate
        if (REFRESH_AFTER_MODE) begin : g_ref_late
            always_comb begin
                if (int'(step) == 0)                   cmd = CMD_PRE;
                else if (int'(step) == 1)              cmd = CMD_MRS;
                else if (int'(step) <= N_REFRESH + 1)  cmd = CMD_REF;
                else                                   cmd = CMD_NOP;
            end
        end else begin : g_ref_early
            always_comb begin
                if (int'(step) == 0)                   cmd = CMD_PRE;
                else if (int'(step) <= N_REFRESH)      cmd = CMD_REF;
                else if (int'(step) == N_REFRESH + 1)  cmd = CMD_MRS;
                else                                   cmd = CMD_NOP;
            end
        end
    endgenerate

    always_comb begin
        case (cmd)
            CMD_PRE: gap = GAP_W'(TRP_CYC);
            CMD_REF: gap = GAP_W'(TRFC_CYC);
            CMD_MRS: gap = GAP_W'(TMRD_CYC);
            default: gap = GAP_W'(1);
        endcase
    end

endmodule

// File: rtl/sdram_init_cmd_encode.sv
module sdram_init_cmd_encode
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                BA_W      = 2,
    parameter int                ALL_BIT   = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h020
) (
    input  init_cmd_e         cmd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        ba   = '0;
        addr = '0;
        cs_n = 1'b0;
        case (cmd)
            CMD_PRE: begin
                {ras_n, cas_n, we_n} = 3'b010;
                addr[ALL_BIT]        = 1'b1;
            end
            CMD_REF: {ras_n, cas_n, we_n} = 3'b001;
            CMD_MRS: begin
                {ras_n, cas_n, we_n} = 3'b000;
                addr                 = MODE_WORD;
            end
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end

endmodule

// File: rtl/sdram_power_up_seq.sv
module sdram_power_up_seq
    import sdram_init_pkg::*;
#(
    parameter int                CLK_PERIOD_PS      = 4000,
    parameter int                STARTUP_NS         = 100000,
    parameter int                CKE_RISE_NS        = 50000,
    parameter int                T_RP_NS            = 20,
    parameter int                T_RFC_NS           = 70,
    parameter int                T_MRD_NS           = 14,
    parameter int                N_REFRESH          = 2,
    parameter bit                REFRESH_AFTER_MODE = 1'b0,
    parameter int                ADDR_W             = 12,
    parameter int                BA_W               = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD          = 'h020
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int STARTUP_CYC = ns_to_cycles(STARTUP_NS, CLK_PERIOD_PS);
    localparam int CKE_RAW_CYC = ns_to_cycles(CKE_RISE_NS, CLK_PERIOD_PS);
    localparam int CKE_CYC     = (CKE_RAW_CYC > STARTUP_CYC) ? STARTUP_CYC : CKE_RAW_CYC;
    localparam int TRP_CYC     = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int TRFC_CYC    = ns_to_cycles(T_RFC_NS, CLK_PERIOD_PS);
    localparam int TMRD_CYC    = ns_to_cycles(T_MRD_NS, CLK_PERIOD_PS);
    localparam int GAP_A       = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
    localparam int MAX_GAP     = (GAP_A > TMRD_CYC) ? GAP_A : TMRD_CYC;
    localparam int CNT_TOP     = (STARTUP_CYC > MAX_GAP) ? STARTUP_CYC : MAX_GAP;
    localparam int CNT_W       = $clog2(CNT_TOP + 2);
    localparam int GAP_W       = $clog2(MAX_GAP + 1);
    localparam int N_STEPS     = N_REFRESH + 2;
    localparam int STEP_W      = $clog2(N_STEPS + 1);

    typedef struct packed {
        init_phase_e       phase;
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
        logic              cke;
        init_cmd_e         cmd;
        logic              done;
    } seq_state_t;

    seq_state_t state_q, state_d;
    init_cmd_e  tbl_cmd;
    logic [GAP_W-1:0] tbl_gap;

    sdram_init_step_table #(
        .N_REFRESH          (N_REFRESH),
        .REFRESH_AFTER_MODE (REFRESH_AFTER_MODE),
        .TRP_CYC            (TRP_CYC),
        .TRFC_CYC           (TRFC_CYC),
        .TMRD_CYC           (TMRD_CYC),
        .STEP_W             (STEP_W),
        .GAP_W              (GAP_W)
    ) u_table (
        .step (state_q.step),
        .cmd  (tbl_cmd),
        .gap  (tbl_gap)
    );

    // Next-state computation: start-up count, then command/spacing steps.
    always_comb begin
        state_d = state_q;
        case (state_q.phase)
            PH_WAIT: begin
                state_d.cmd = CMD_NOP;
                state_d.cnt = state_q.cnt + 1'b1;
                if (int'(state_q.cnt) + 1 >= CKE_CYC) state_d.cke = 1'b1;
                if (state_q.cnt == CNT_W'(STARTUP_CYC)) begin
                    state_d.phase = PH_GAP;
                    state_d.cke   = 1'b1;
                    state_d.cmd   = tbl_cmd;
                    state_d.cnt   = CNT_W'(tbl_gap);
                    state_d.step  = state_q.step + 1'b1;
                end
            end
            PH_GAP: begin
                state_d.cke = 1'b1;
                state_d.cmd = CMD_NOP;
                state_d.cnt = state_q.cnt - 1'b1;
                if (state_q.cnt == CNT_W'(1)) begin
                    if (state_q.step == STEP_W'(N_STEPS)) begin
                        state_d.phase = PH_DONE;
                        state_d.done  = 1'b1;
                    end else begin
                        state_d.cmd  = tbl_cmd;
                        state_d.cnt  = CNT_W'(tbl_gap);
                        state_d.step = state_q.step + 1'b1;
                    end
                end
            end
            default: begin
                state_d.cke  = 1'b1;
                state_d.cmd  = CMD_NOP;
                state_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '{phase: PH_WAIT, cnt: '0, step: '0,
                         cke: 1'b0, cmd: CMD_NOP, done: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    sdram_init_cmd_encode #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .ALL_BIT   (10),
        .MODE_WORD (MODE_WORD)
    ) u_encode (
        .cmd   (state_q.cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

    assign cke       = state_q.cke;
    assign init_done = state_q.done;

    // R3
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R2
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R4
    pre_all_bit_chk: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr[10] && cke));

    // R7
    mode_word_chk: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0000) |-> (addr == MODE_WORD && ba == '0));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke));

endmodule

// File: tb/sdram_power_up_seq_test.sv
`timescale 1ns/1ps
module sdram_power_up_seq_test;

    localparam int S_CYC  = 25000;   // 100 us at 4 ns
    localparam int CK_CYC = 12500;   // 50 us at 4 ns
    localparam int P_CYC  = 5;       // ceil(20/4)
    localparam int F_CYC  = 18;      // ceil(70/4)
    localparam int M_CYC  = 4;       // ceil(14/4)
    localparam int RUN_TO = 25060;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       cke0, cs0, ras0, cas0, we0, dn0;
    logic [1:0] ba0;
    logic [11:0] a0;
    logic       cke1, cs1, ras1, cas1, we1, dn1;
    logic [1:0] ba1;
    logic [11:0] a1;

    sdram_power_up_seq #(.REFRESH_AFTER_MODE(1'b0), .MODE_WORD(12'h020)) uut (
        .clk(clk), .rst(rst), .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0),
        .we_n(we0), .ba(ba0), .addr(a0), .init_done(dn0));

    sdram_power_up_seq #(.REFRESH_AFTER_MODE(1'b1), .MODE_WORD(12'h033)) uut_alt (
        .clk(clk), .rst(rst), .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1),
        .we_n(we1), .ba(ba1), .addr(a1), .init_done(dn1));

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    bit live   = 1'b0;

    int sched_cyc [2][4];
    int sched_cmd [2][4];
    int sched_gap [2][4];
    int done_cyc  [2];
    logic [11:0] mode_w [2];
    int obs_cyc0[$], obs_cmd0[$], obs_cyc1[$], obs_cmd1[$];

    always @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, k, act, exp);
        end
    endtask

    // 0 nop, 1 precharge, 2 refresh, 3 mode load, 9 other
    function automatic int decode(input logic cs, ras, cas, we);
        case ({cs, ras, cas, we})
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return 3;
            default: return 9;
        endcase
    endfunction

    task automatic build_model();
        int order0[4] = '{1, 2, 2, 3};
        int order1[4] = '{1, 3, 2, 2};
        for (int i = 0; i < 2; i++) begin
            int t = S_CYC + 1;
            for (int j = 0; j < 4; j++) begin
                int c = (i == 0) ? order0[j] : order1[j];
                sched_cmd[i][j] = c;
                sched_cyc[i][j] = t;
                sched_gap[i][j] = (c == 1) ? P_CYC : (c == 2) ? F_CYC : M_CYC;
                t += sched_gap[i][j];
            end
            done_cyc[i] = t;
        end
        mode_w[0] = 12'h020;
        mode_w[1] = 12'h033;
    endtask

    task automatic cycle_check(input int i, input logic ck, cs, ras, cas, we,
                               input logic [1:0] b, input logic [11:0] a, input logic dn);
        int ec = 0;
        int ac;
        int ea = 0;
        string tag;
        for (int j = 0; j < 4; j++)
            if (sched_cyc[i][j] == k) ec = sched_cmd[i][j];
        if (ec == 1) ea = 12'h400;
        if (ec == 3) ea = int'(mode_w[i]);
        ac = decode(cs, ras, cas, we);
        if (ec == 1)                 tag = "R4";
        else if (ec == 2 || ec == 3) tag = "R7";
        else if (k <= S_CYC)         tag = "R2";
        else if (k >= done_cyc[i])   tag = "R9";
        else                         tag = "R8";
        check(ck == (k >= CK_CYC), "R3", $sformatf("cke inst%0d", i), int'(ck), int'(k >= CK_CYC));
        check(ac == ec && int'(a) == ea && b == 2'b00, tag, $sformatf("cmd/addr inst%0d", i),
              (ac << 16) | (int'(b) << 12) | int'(a), (ec << 16) | ea);
        check(dn == (k >= done_cyc[i]), "R9", $sformatf("done inst%0d", i),
              int'(dn), int'(k >= done_cyc[i]));
    endtask

    // Per-cycle comparison and command recording, sampled on the falling edge.
    always @(negedge clk) begin
        if (live && !rst) begin
            int c0, c1;
            cycle_check(0, cke0, cs0, ras0, cas0, we0, ba0, a0, dn0);
            cycle_check(1, cke1, cs1, ras1, cas1, we1, ba1, a1, dn1);
            c0 = decode(cs0, ras0, cas0, we0);
            c1 = decode(cs1, ras1, cas1, we1);
            if (c0 != 0) begin obs_cyc0.push_back(k); obs_cmd0.push_back(c0); end
            if (c1 != 0) begin obs_cyc1.push_back(k); obs_cmd1.push_back(c1); end
        end
    end

    task automatic reset_state_check(input string tag);
        check(cke0 == 0 && cke1 == 0, tag, "cke in reset", int'({cke0, cke1}), 0);
        check({cs0, ras0, cas0, we0} == 4'b0111 && {cs1, ras1, cas1, we1} == 4'b0111,
              tag, "nop in reset", int'({cs0, ras0, cas0, we0, cs1, ras1, cas1, we1}), 8'h77);
        check(a0 == 0 && a1 == 0 && ba0 == 0 && ba1 == 0, tag, "bus zero in reset",
              int'({ba0, a0}), 0);
        check(dn0 == 0 && dn1 == 0, tag, "done in reset", int'({dn0, dn1}), 0);
    endtask

    task automatic run_end_checks(input string run_tag);
        check(obs_cmd0.size() == 4, "R5", "command count inst0", obs_cmd0.size(), 4);
        check(obs_cmd1.size() == 4, "R6", "command count inst1", obs_cmd1.size(), 4);
        for (int j = 0; j < 4 && j < obs_cmd0.size(); j++)
            check(obs_cmd0[j] == sched_cmd[0][j], "R5", "order inst0", obs_cmd0[j], sched_cmd[0][j]);
        for (int j = 0; j < 4 && j < obs_cmd1.size(); j++)
            check(obs_cmd1[j] == sched_cmd[1][j], "R6", "order inst1", obs_cmd1[j], sched_cmd[1][j]);
        for (int j = 0; j + 1 < obs_cyc0.size() && j < 3; j++)
            check(obs_cyc0[j+1] - obs_cyc0[j] == sched_gap[0][j], "R8", "spacing inst0",
                  obs_cyc0[j+1] - obs_cyc0[j], sched_gap[0][j]);
        for (int j = 0; j + 1 < obs_cyc1.size() && j < 3; j++)
            check(obs_cyc1[j+1] - obs_cyc1[j] == sched_gap[1][j], "R8", "spacing inst1",
                  obs_cyc1[j+1] - obs_cyc1[j], sched_gap[1][j]);
        if (obs_cyc0.size() > 0)
            check(obs_cyc0[0] == S_CYC + 1, run_tag, "first command cycle inst0", obs_cyc0[0], S_CYC + 1);
        if (obs_cyc1.size() > 0)
            check(obs_cyc1[0] == S_CYC + 1, run_tag, "first command cycle inst1", obs_cyc1[0], S_CYC + 1);
        check(dn0 && dn1, run_tag, "done at end of run", int'({dn0, dn1}), 3);
        obs_cyc0.delete(); obs_cmd0.delete(); obs_cyc1.delete(); obs_cmd1.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired at cycle %0d: actual hung expected finished", k);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        build_model();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        reset_state_check("R1");
        @(posedge clk); #1;
        rst  = 1'b0;
        live = 1'b1;
        while (k < RUN_TO) @(negedge clk);
        run_end_checks("R2");

        // Second run: reset applied mid-window after cke has risen.
        @(posedge clk); #1;
        rst = 1'b1;
        @(negedge clk);
        reset_state_check("R1");
        @(posedge clk); #1;
        rst = 1'b0;
        while (k < CK_CYC + 500) @(negedge clk);
        @(posedge clk); #1;
        rst = 1'b1;
        @(negedge clk);
        reset_state_check("R10");
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        rst = 1'b0;
        while (k < RUN_TO) @(negedge clk);
        run_end_checks("R10");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule